// File: doc/BRIEF.md
# Dual Event Counter Unit

A performance-monitoring block with two 40-bit counters and one shared control register. Software reads and writes all three through a small register port. Every cycle the block receives a vector of event strobes, one bit per event code, and the current 2-bit privilege level.

Each counter has its own control field. The field selects which strobe it watches, or switches the counter to count clock cycles. It holds separate enables for privilege level 3 and for levels 0 to 2. It also chooses what the counter's indicator pin reports: every increment, or only a wrap from all ones to zero.

Counter values and pin pulses are registered on the same edge. The pin is high in the cycle after the edge that counted. The register port is a single-cycle write strobe with a combinational read.

Top module: `evcnt_unit`

## Requirements
- R1: After reset the control register, both counters and both pins are zero, and no counter advances until software writes the control register.
- R2: Register address 0 selects the control register, address 1 counter 0 and address 2 counter 1. Address 3 reads zero and ignores writes. `reg_rdata` shows the addressed register in the same cycle, and a write takes effect on the next rising clock edge.
- R3: Counter 0 is controlled by control bits 9:0 and counter 1 by bits 25:16, with the same layout in each field. Field bits 5:0 select the event, bit 6 enables levels 0 to 2, bit 7 enables level 3, bit 8 selects clock mode and bit 9 selects overflow indication.
- R4: In event mode a counter adds one on a clock edge when `evt_strobe[select]` is high and the enable for the current level is set. It does not change on a strobe at any other index.
- R5: When `cpl` is 3 only the level-3 enable gates counting; when `cpl` is 0, 1 or 2 only the levels-0-to-2 enable does.
- R6: In clock mode a counter adds one on every edge whatever the select and strobes, still gated by the privilege enable for the current level.
- R7: A counter whose two privilege enables are both clear holds its value.
- R8: A counter wraps from all ones (2^40-1) to zero.
- R9: With the overflow-indication bit clear, the counter's pin is high for exactly one cycle after each edge on which the counter incremented.
- R10: With the overflow-indication bit set, the pin is high for one cycle only after an increment that wrapped the counter to zero.
- R11: Control bits 15:10 and 31:26 always read zero, whatever was written, and the upper 8 bits of a control read are zero.
- R12: A software write to a counter on the same edge as an increment loads the written value and leaves the pin low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 counter 0, 2 counter 1) |
| reg_wdata | input | 40 | Write data |
| reg_rdata | output | 40 | Read data of the addressed register |
| evt_strobe | input | 64 | Per-cycle event strobes, bit n is event code n |
| cpl | input | 2 | Current privilege level |
| cnt_pin | output | 2 | Per-counter indicator pulse |

## Verification
The counting function is tried in several ways, each aimed at one fault:
- Matching and non-matching strobe indices separate a correct select mux from one that ignores the select.
- All four privilege levels run against each enable alone, which exposes a swapped or mis-decoded level test.
- Clock mode with a non-matching select shows that the mode bypasses the mux.
- Counters preloaded just below the wrap point, run in both pin modes, tell apart a pin that follows increments from one that follows wraps.
- Counter 1 is run with its own field, so a shifted field offset shows up.
- A write landing on an active counting edge confirms that the write wins.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   // register port selection codes
   typedef enum logic [1:0] {
      RS_CTRL = 2'd0,
      RS_CNT0 = 2'd1,
      RS_CNT1 = 2'd2,
      RS_VOID = 2'd3
   } reg_sel_e;

   // spacing between per-counter control fields in the control register
   localparam int FLD_STRIDE = 16;
   // bits of a field beyond the event select: low-level en, level-3 en, clock, overflow
   localparam int FLD_EXTRA  = 4;
endpackage

// File: rtl/evcnt_ctrl_reg.sv
module evcnt_ctrl_reg
   import evcnt_pkg::*;
#(
   parameter int SEL_W   = 6,
   parameter int NUM_CNT = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [NUM_CNT*FLD_STRIDE-1:0]   wdata,
   output logic [NUM_CNT*FLD_STRIDE-1:0]   ctrl_q
);
   localparam int FIELD_W = SEL_W + FLD_EXTRA;
   localparam int CTRL_W  = NUM_CNT * FLD_STRIDE;

   logic [CTRL_W-1:0] wr_mask;

   // writable bits: the low FIELD_W bits of every stride
   for (genvar i = 0; i < NUM_CNT; i++) begin : g_mask
      if (FIELD_W < FLD_STRIDE) begin : g_pad
         assign wr_mask[i*FLD_STRIDE +: FLD_STRIDE] =
            {{(FLD_STRIDE-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};
      end else begin : g_full
         assign wr_mask[i*FLD_STRIDE +: FLD_STRIDE] = {FLD_STRIDE{1'b1}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata & wr_mask;
   end
endmodule

// File: rtl/evcnt_gate.sv
module evcnt_gate #(
   parameter int SEL_W = 6,
   parameter int EXTRA = 4
) (
   input  logic [(1<<SEL_W)-1:0]   evt,
   input  logic [SEL_W+EXTRA-1:0]  field,
   input  logic [1:0]              cpl,
   output logic                    inc,
   output logic                    ovf_mode
);
   logic [SEL_W-1:0] sel;
   logic             en_low, en_top, clk_mode, lvl_ok, src_hit;

   assign sel      = field[SEL_W-1:0];
   assign en_low   = field[SEL_W];
   assign en_top   = field[SEL_W+1];
   assign clk_mode = field[SEL_W+2];
   assign ovf_mode = field[SEL_W+3];

   always_comb begin
      lvl_ok  = (cpl == 2'd3) ? en_top : en_low;
      src_hit = clk_mode | evt[sel];
      inc     = lvl_ok & src_hit;
   end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
   parameter int CNT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   input  logic             ovf_mode,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pin_q
);
   logic at_top;
   assign at_top = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pin_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         pin_q <= 1'b0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
         pin_q <= ovf_mode ? at_top : 1'b1;
      end else begin
         pin_q <= 1'b0;
      end
   end
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
   import evcnt_pkg::*;
#(
   parameter int CNT_W   = 40,
   parameter int SEL_W   = 6,
   parameter int NUM_CNT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [1:0]               reg_addr,
   input  logic [CNT_W-1:0]         reg_wdata,
   output logic [CNT_W-1:0]         reg_rdata,
   input  logic [(1<<SEL_W)-1:0]    evt_strobe,
   input  logic [1:0]               cpl,
   output logic [NUM_CNT-1:0]       cnt_pin
);
   localparam int FIELD_W = SEL_W + FLD_EXTRA;
   localparam int CTRL_W  = NUM_CNT * FLD_STRIDE;

   if (NUM_CNT < 1 || NUM_CNT > 2) begin : g_bad_num
      $error("evcnt_unit: NUM_CNT must be 1 or 2");
   end
   if (FIELD_W > FLD_STRIDE) begin : g_bad_field
      $error("evcnt_unit: control field wider than its stride");
   end
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("evcnt_unit: CNT_W must cover the control register");
   end

   logic [CTRL_W-1:0]                ctrl_q;
   logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_q;
   logic                             ctrl_wr;

   assign ctrl_wr = reg_wr && (reg_sel_e'(reg_addr) == RS_CTRL);

   evcnt_ctrl_reg #(.SEL_W(SEL_W), .NUM_CNT(NUM_CNT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctrl_wr),
      .wdata  (reg_wdata[CTRL_W-1:0]),
      .ctrl_q (ctrl_q)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic inc, ovf_mode, load;

      assign load = reg_wr && (reg_addr == 2'(i + 1));

      evcnt_gate #(.SEL_W(SEL_W), .EXTRA(FLD_EXTRA)) u_gate (
         .evt      (evt_strobe),
         .field    (ctrl_q[i*FLD_STRIDE +: FIELD_W]),
         .cpl      (cpl),
         .inc      (inc),
         .ovf_mode (ovf_mode)
      );

      evcnt_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .load_val (reg_wdata),
         .inc      (inc),
         .ovf_mode (ovf_mode),
         .cnt_q    (cnt_q[i]),
         .pin_q    (cnt_pin[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_addr))
         RS_CTRL: reg_rdata = CNT_W'(ctrl_q);
         RS_CNT0: reg_rdata = cnt_q[0];
         RS_CNT1: if (NUM_CNT > 1) reg_rdata = cnt_q[NUM_CNT-1];
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk
   import evcnt_pkg::*;
#(
   parameter int CNT_W   = 40,
   parameter int SEL_W   = 6,
   parameter int NUM_CNT = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           reg_wr,
   input logic [1:0]                     reg_addr,
   input logic [CNT_W-1:0]               reg_wdata,
   input logic [NUM_CNT*FLD_STRIDE-1:0]  ctrl_q,
   input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q,
   input logic [NUM_CNT-1:0]             cnt_pin
);
   localparam int FIELD_W = SEL_W + FLD_EXTRA;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
      localparam int B = i * FLD_STRIDE;

      // R12: write to the counter wins over any increment
      a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == 2'(i + 1)) |=> (cnt_q[i] == $past(reg_wdata) && !cnt_pin[i]));

      // R7: both privilege enables clear and no write -> value held
      a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl_q[B+SEL_W] && !ctrl_q[B+SEL_W+1] && !(reg_wr && reg_addr == 2'(i + 1)))
         |=> $stable(cnt_q[i]));

      // R10: in overflow indication the pin only follows a wrap to zero
      a_r10_pin_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_pin[i] && $past(ctrl_q[B+SEL_W+3])) |-> (cnt_q[i] == '0));

      // R9: in increment indication the pin follows a single-step advance
      a_r9_pin_on_step: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_pin[i] && !$past(ctrl_q[B+SEL_W+3])) |-> (cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1)));

      // R11: reserved control bits stay zero
      a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_q[B+FIELD_W +: (FLD_STRIDE-FIELD_W)] == '0);
   end
endmodule

bind evcnt_unit evcnt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NUM_CNT(NUM_CNT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .ctrl_q    (ctrl_q),
   .cnt_q     (cnt_q),
   .cnt_pin   (cnt_pin)
);

// File: tb/sim_evcnt_unit.sv
module sim_evcnt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [39:0] reg_wdata = '0;
   logic [39:0] reg_rdata;
   logic [63:0] evt_strobe = '0;
   logic [1:0]  cpl = 2'd0;
   logic [1:0]  cnt_pin;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   evcnt_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe),
      .cpl(cpl), .cnt_pin(cnt_pin)
   );

   typedef struct packed {
      logic [31:0] ctl;
      logic        cidx;
      logic [39:0] pre;
      logic [5:0]  ev;
      logic [1:0]  lvl;
      logic [7:0]  n;
      logic [39:0] exp_cnt;
      logic [7:0]  exp_pul;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0045, 1'b0, 40'd0, 6'd5, 2'd0, 8'd4, 40'd4, 8'd4},                       // R4 match, low level
      '{32'h0000_0045, 1'b0, 40'd0, 6'd5, 2'd3, 8'd4, 40'd0, 8'd0},                       // R5 level 3 disabled
      '{32'h0000_0085, 1'b0, 40'd0, 6'd5, 2'd3, 8'd4, 40'd4, 8'd4},                       // R5 level 3 enabled
      '{32'h0000_0085, 1'b0, 40'd0, 6'd5, 2'd2, 8'd4, 40'd0, 8'd0},                       // R5 level 2 uses low enable
      '{32'h0000_0047, 1'b0, 40'd0, 6'd5, 2'd1, 8'd4, 40'd0, 8'd0},                       // R4 select mismatch
      '{32'h0000_0147, 1'b0, 40'd0, 6'd5, 2'd0, 8'd3, 40'd4, 8'd4},                       // R6 clock mode
      '{32'h0000_0180, 1'b0, 40'd0, 6'd0, 2'd1, 8'd3, 40'd0, 8'd0},                       // R6 clock mode, level blocked
      '{32'h0000_027F, 1'b0, 40'hFF_FFFF_FFFE, 6'd63, 2'd0, 8'd3, 40'd1, 8'd1},           // R10 R8 wrap pulse
      '{32'h0000_0040, 1'b0, 40'hFF_FFFF_FFFF, 6'd0, 2'd0, 8'd2, 40'd1, 8'd2},            // R9 R8 increment pulses
      '{32'h00EA_0000, 1'b1, 40'd100, 6'd42, 2'd3, 8'd5, 40'd105, 8'd5},                  // R3 counter 1 field
      '{32'h0340_0000, 1'b1, 40'hFF_FFFF_FFFD, 6'd0, 2'd0, 8'd3, 40'd1, 8'd1},            // R10 counter 1 clock+wrap
      '{32'h0000_0005, 1'b0, 40'd77, 6'd5, 2'd0, 8'd4, 40'd77, 8'd0}                      // R7 both enables clear
   };

   task automatic check(string req, string what, logic [39:0] act, logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [39:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic run_vec(int k);
      vec_t v = VECS[k];
      int pul = 0;
      string tag;
      tag = $sformatf("R4/R5/R6/R7/R8/R9/R10 vec%0d", k);
      wr(2'd0, 40'd0);
      wr({1'b0, v.cidx} + 2'd1, v.pre);
      wr(2'd0, {8'd0, v.ctl});
      cpl = v.lvl;
      for (int j = 1; j <= int'(v.n) + 1; j++) begin
         @(negedge clk);
         if (j >= 2) pul += int'(cnt_pin[v.cidx]);
         evt_strobe = (j <= int'(v.n)) ? (64'd1 << v.ev) : 64'd0;
         reg_wr = (j == int'(v.n) + 1);
         reg_addr = 2'd0; reg_wdata = 40'd0;
      end
      @(negedge clk);
      pul += int'(cnt_pin[v.cidx]);
      reg_wr = 1'b0;
      reg_addr = {1'b0, v.cidx} + 2'd1;
      #1;
      check(tag, "count", reg_rdata, v.exp_cnt);
      check(tag, "pin pulses", 40'(pul), 40'(v.exp_pul));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R1), checked at the ports while held
      reg_addr = 2'd0; #1; check("R1", "ctrl at reset", reg_rdata, 40'd0);
      reg_addr = 2'd1; #1; check("R1", "cnt0 at reset", reg_rdata, 40'd0);
      reg_addr = 2'd2; #1; check("R1", "cnt1 at reset", reg_rdata, 40'd0);
      check("R1", "pins at reset", 40'(cnt_pin), 40'd0);
      rst_n = 1'b1;
      evt_strobe = '1;
      repeat (4) @(negedge clk);
      reg_addr = 2'd1; #1; check("R1", "cnt0 idle after reset", reg_rdata, 40'd0);
      evt_strobe = '0;

      // R2: counter write/read and empty address
      wr(2'd2, 40'hA5_1234_5678);
      @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd2; #1;
      check("R2", "cnt1 readback", reg_rdata, 40'hA5_1234_5678);
      wr(2'd3, 40'hFF_FFFF_FFFF);
      @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd3; #1;
      check("R2", "address 3 reads zero", reg_rdata, 40'd0);

      // R11: reserved bits
      wr(2'd0, 40'hFF_FFFF_FFFF);
      @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0; #1;
      check("R11", "reserved masked", reg_rdata, 40'h00_03FF_03FF);
      wr(2'd0, 40'd0);
      @(negedge clk); reg_wr = 1'b0;

      for (int k = 0; k < NV; k++) run_vec(k);

      // R12: write lands on a counting edge
      wr(2'd1, 40'd10);
      wr(2'd0, 40'h0000_0140);
      cpl = 2'd0;
      @(negedge clk); reg_wr = 1'b0;
      wr(2'd1, 40'd500);
      @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd1; #1;
      check("R12", "write wins", reg_rdata, 40'd500);
      check("R12", "pin low on write", 40'(cnt_pin[0]), 40'd0);
      @(negedge clk); #1;
      check("R12", "counts after write", reg_rdata, 40'd501);
      wr(2'd0, 40'd0);
      @(negedge clk); reg_wr = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule